// File: doc/BRIEF.md
# Bus Master Burst Tracker

This block follows a single burst issued by a bus master on a PCI-style shared bus, from the local start request until the burst ends. It reports the burst's phase on a one-hot status output. It keeps a latency timer and a down-counter of the data phases still to move. When the burst ends, it decides which of eight causes ended it and presents that cause as a 3-bit code.

Ending causes can coincide, so they are ranked:
1. target abort
2. no device select response
3. local abort
4. target stop
5. last data phase
6. timer expiry
7. cacheline boundary of a Memory Write and Invalidate burst

A timeout flag records that the latency timer reached zero while grant was low. The flag is kept apart from the code, because a burst whose timer runs out on its final data phase still ends normally.

A new start request that arrives while a burst is ending begins a back-to-back burst, which skips the idle state.

Top module: `masterBurstTracker`

## Requirements
- R1: statusOut is 4'b0000 when idle and after reset, 4'b0001 in the single address cycle, 4'b0010 while data moves, 4'b0100 in the single ending cycle and 4'b1000 in a back-to-back address cycle. It never has more than one bit set.
- R2: Accepting a start loads burstCnt as follows: burstLen when wide64Req is 0, burstLen when wide64Req and wide64Ack are both 1, and twice burstLen when wide64Req is 1 and wide64Ack is 0 (burstLen below 4096). Each data phase that completes (devSel and targetReady high while statusOut is 4'b0010) lowers it by one.
- R3: A completed data phase taken with burstCnt at 1 ends the burst with termCode 3'b000. This holds even when the latency timer is zero and busGrant is low on that phase, in which case timeoutFlag is also set.
- R4: The latency timer loads latPreset on a start and drops by one per cycle in the address and data phases, stopping at zero. In a burst that is not Memory Write and Invalidate, a completed data phase with burstCnt above 1, the timer at zero and busGrant low ends the burst with termCode 3'b001 and timeoutFlag high.
- R5: In a Memory Write and Invalidate burst (mwiCmd high), timer expiry alone never ends the burst, although timeoutFlag is still set. With localAbort high, the burst ends on the completed data phase whose word position, which starts at startWord and wraps modulo lineWords, equals lineWords-1. That ending gives termCode 3'b001 if timeoutFlag is set and 3'b111 otherwise.
- R6: Four data-state cycles without devSel, with devSel never seen in the burst, end it with termCode 3'b010.
- R7: targetAbort in the data state ends the burst with termCode 3'b011, ahead of every other cause.
- R8: targetStop ends the burst with termCode 3'b100 when targetReady is low and no data phase has completed yet, and with termCode 3'b101 otherwise.
- R9: busGrant low in an address cycle ends the burst in the next cycle with termCode 3'b110 and no data phase.
- R10: localAbort in a burst that is not Memory Write and Invalidate ends it with termCode 3'b111. It outranks targetStop.
- R11: The ending state lasts exactly one cycle. A targetReady strobe during that cycle is a prefetched word and leaves burstCnt unchanged.
- R12: startReq high during the ending cycle gives statusOut 4'b1000, loads the new burst, and continues to 4'b0010.
- R13: termCode and timeoutFlag reset to 3'b000 and 0. They hold from the end of a burst until the next start is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Local request to begin a burst |
| burstLen | input | 13 | Requested number of data phases |
| wide64Req | input | 1 | Burst requested as 64-bit |
| wide64Ack | input | 1 | 64-bit transfer accepted |
| mwiCmd | input | 1 | Burst uses Memory Write and Invalidate |
| busGrant | input | 1 | Bus grant, active high |
| targetReady | input | 1 | Target ready for the data phase |
| targetStop | input | 1 | Target requests a stop |
| devSel | input | 1 | Target claimed the transaction |
| targetAbort | input | 1 | Target signals an abort |
| latPreset | input | 8 | Latency timer start value |
| lineWords | input | 8 | Cacheline size in words (at least 1) |
| startWord | input | 8 | Word position of the first address within its line |
| localAbort | input | 1 | Local side asks to end the burst |
| statusOut | output | 4 | One-hot phase status |
| termCode | output | 3 | Cause of the last burst ending |
| timeoutFlag | output | 1 | Latency timer expired with grant low |
| burstCnt | output | 13 | Remaining data phase count |

## Verification
Every output is registered, so each result falls due at the first rising edge that samples its cause. Inputs change on the falling edge and outputs are read on the next falling edge, half a period after the edge that updated them.

A start accepted at one edge shows as the address status and the loaded count at the next sample. The data state follows one edge later, and each completed data phase lowers the count at the edge that samples it. The ending status and its code appear together at the edge that samples the ending condition, and idle or the back-to-back status follows one edge after that.

The timer cases are set up so the timer reaches zero on the intended data phase. That edge is the load at the start, one decrement in the address cycle, then one per data cycle.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

  typedef enum logic [3:0] {
    PH_IDLE = 4'b0000,
    PH_ADDR = 4'b0001,
    PH_XFER = 4'b0010,
    PH_END  = 4'b0100,
    PH_FBB  = 4'b1000
  } phase_e;

  typedef enum logic [2:0] {
    TC_NORMAL   = 3'b000,
    TC_TIMEOUT  = 3'b001,
    TC_NORESP   = 3'b010,
    TC_TABORT   = 3'b011,
    TC_RETRY    = 3'b100,
    TC_DISCON   = 3'b101,
    TC_GNTLOST  = 3'b110,
    TC_LOCAL    = 3'b111
  } term_e;

  typedef struct packed {
    logic load;       // new burst accepted this cycle
    logic tick;       // latency timer decrement enable
    logic phaseDone;  // a data phase completes this cycle
    logic inXfer;     // data state, drives the device select watch
  } dpStrobe_t;

endpackage

// File: rtl/bmtDatapath.sv
module bmtDatapath
  import bmt_pkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int LAT_W       = 8,
  parameter int LINE_W      = 8,
  parameter int DEVSEL_WAIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CNT_W-1:0]  burstLen,
  input  logic              wide64Req,
  input  logic              wide64Ack,
  input  logic [LAT_W-1:0]  latPreset,
  input  logic [LINE_W-1:0] lineWords,
  input  logic [LINE_W-1:0] startWord,
  input  logic              devSel,
  output logic [CNT_W-1:0]  burstCnt,
  output logic              cntIsOne,
  output logic              timerZero,
  output logic              lineEnd,
  output logic              devselExpired,
  output logic              anyData
);

  localparam int WAIT_W = $clog2(DEVSEL_WAIT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(DEVSEL_WAIT - 1);

  logic [LAT_W-1:0]  latTimer;
  logic [LINE_W-1:0] wordPos;
  logic [LINE_W-1:0] lastWord;
  logic [WAIT_W-1:0] waitCnt;
  logic              devselSeen;
  logic              doubleLen;

  assign doubleLen = wide64Req && !wide64Ack;
  assign lastWord  = lineWords - 1'b1;

  // burst down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstCnt <= '0;
    end else if (strobe.load) begin
      burstCnt <= doubleLen ? {burstLen[CNT_W-2:0], 1'b0} : burstLen;
    end else if (strobe.phaseDone && burstCnt != '0) begin
      burstCnt <= burstCnt - 1'b1;
    end
  end

  // latency timer, saturating at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latTimer <= '0;
    end else if (strobe.load) begin
      latTimer <= latPreset;
    end else if (strobe.tick && latTimer != '0) begin
      latTimer <= latTimer - 1'b1;
    end
  end

  // word position inside the cacheline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordPos <= '0;
      anyData <= 1'b0;
    end else if (strobe.load) begin
      wordPos <= startWord;
      anyData <= 1'b0;
    end else if (strobe.phaseDone) begin
      wordPos <= (wordPos >= lastWord) ? '0 : wordPos + 1'b1;
      anyData <= 1'b1;
    end
  end

  // device select watch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt    <= '0;
      devselSeen <= 1'b0;
    end else if (strobe.load) begin
      waitCnt    <= '0;
      devselSeen <= 1'b0;
    end else if (strobe.inXfer) begin
      if (devSel) begin
        devselSeen <= 1'b1;
      end else if (!devselSeen && waitCnt != WAIT_LAST) begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  assign cntIsOne      = (burstCnt == CNT_W'(1));
  assign timerZero     = (latTimer == '0);
  assign lineEnd       = (wordPos == lastWord);
  assign devselExpired = !devselSeen && !devSel && (waitCnt == WAIT_LAST);

endmodule

// File: rtl/bmtControl.sv
module bmtControl
  import bmt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      mwiCmd,
  input  logic      busGrant,
  input  logic      targetReady,
  input  logic      targetStop,
  input  logic      devSel,
  input  logic      targetAbort,
  input  logic      localAbort,
  input  logic      cntIsOne,
  input  logic      timerZero,
  input  logic      lineEnd,
  input  logic      devselExpired,
  input  logic      anyData,
  output dpStrobe_t strobe,
  output phase_e    phase,
  output term_e     code,
  output logic      timeoutFlag
);

  phase_e phaseNext;
  logic   startOk;
  logic   phaseOk;
  logic   timeoutNow;
  logic   endNow;
  term_e  endCode;

  assign startOk    = startReq && (phase == PH_IDLE || phase == PH_END);
  assign phaseOk    = (phase == PH_XFER) && devSel && targetReady;
  assign timeoutNow = (phase == PH_XFER) && timerZero && !busGrant;

  // ending decision in the data state, ranked
  always_comb begin
    endNow  = 1'b0;
    endCode = TC_NORMAL;
    if (phase == PH_XFER) begin
      if (targetAbort) begin
        endNow  = 1'b1;
        endCode = TC_TABORT;
      end else if (devselExpired) begin
        endNow  = 1'b1;
        endCode = TC_NORESP;
      end else if (localAbort && !mwiCmd) begin
        endNow  = 1'b1;
        endCode = TC_LOCAL;
      end else if (targetStop) begin
        endNow  = 1'b1;
        endCode = (!targetReady && !anyData) ? TC_RETRY : TC_DISCON;
      end else if (phaseOk && cntIsOne) begin
        endNow  = 1'b1;
        endCode = TC_NORMAL;
      end else if (phaseOk && !mwiCmd && timeoutNow) begin
        endNow  = 1'b1;
        endCode = TC_TIMEOUT;
      end else if (phaseOk && mwiCmd && localAbort && lineEnd) begin
        endNow  = 1'b1;
        endCode = (timeoutFlag || timeoutNow) ? TC_TIMEOUT : TC_LOCAL;
      end
    end
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (startOk) phaseNext = PH_ADDR;
      PH_ADDR,
      PH_FBB:  phaseNext = busGrant ? PH_XFER : PH_END;
      PH_XFER: if (endNow) phaseNext = PH_END;
      PH_END:  phaseNext = startOk ? PH_FBB : PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phaseNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code        <= TC_NORMAL;
      timeoutFlag <= 1'b0;
    end else if (startOk) begin
      code        <= TC_NORMAL;
      timeoutFlag <= 1'b0;
    end else begin
      if ((phase == PH_ADDR || phase == PH_FBB) && !busGrant) begin
        code <= TC_GNTLOST;
      end else if (endNow) begin
        code <= endCode;
      end
      if (timeoutNow) begin
        timeoutFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load      = startOk;
    strobe.tick      = (phase == PH_ADDR) || (phase == PH_FBB) || (phase == PH_XFER);
    strobe.phaseDone = phaseOk;
    strobe.inXfer    = (phase == PH_XFER);
  end

endmodule

// File: rtl/masterBurstTracker.sv
module masterBurstTracker
  import bmt_pkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int LAT_W       = 8,
  parameter int LINE_W      = 8,
  parameter int DEVSEL_WAIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  burstLen,
  input  logic              wide64Req,
  input  logic              wide64Ack,
  input  logic              mwiCmd,
  input  logic              busGrant,
  input  logic              targetReady,
  input  logic              targetStop,
  input  logic              devSel,
  input  logic              targetAbort,
  input  logic [LAT_W-1:0]  latPreset,
  input  logic [LINE_W-1:0] lineWords,
  input  logic [LINE_W-1:0] startWord,
  input  logic              localAbort,
  output logic [3:0]        statusOut,
  output logic [2:0]        termCode,
  output logic              timeoutFlag,
  output logic [CNT_W-1:0]  burstCnt
);

  dpStrobe_t strobe;
  phase_e    phase;
  term_e     code;
  logic      cntIsOne;
  logic      timerZero;
  logic      lineEnd;
  logic      devselExpired;
  logic      anyData;

  bmtControl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .mwiCmd(mwiCmd),
    .busGrant(busGrant), .targetReady(targetReady), .targetStop(targetStop),
    .devSel(devSel), .targetAbort(targetAbort), .localAbort(localAbort),
    .cntIsOne(cntIsOne), .timerZero(timerZero), .lineEnd(lineEnd),
    .devselExpired(devselExpired), .anyData(anyData),
    .strobe(strobe), .phase(phase), .code(code), .timeoutFlag(timeoutFlag)
  );

  bmtDatapath #(
    .CNT_W(CNT_W), .LAT_W(LAT_W), .LINE_W(LINE_W), .DEVSEL_WAIT(DEVSEL_WAIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .burstLen(burstLen),
    .wide64Req(wide64Req), .wide64Ack(wide64Ack), .latPreset(latPreset),
    .lineWords(lineWords), .startWord(startWord), .devSel(devSel),
    .burstCnt(burstCnt), .cntIsOne(cntIsOne), .timerZero(timerZero),
    .lineEnd(lineEnd), .devselExpired(devselExpired), .anyData(anyData)
  );

  assign statusOut = phase;
  assign termCode  = code;

endmodule

// File: rtl/bmtChecker.sv
module bmtChecker #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [CNT_W-1:0] burstLen,
  input logic             wide64Req,
  input logic             wide64Ack,
  input logic             busGrant,
  input logic [3:0]       statusOut,
  input logic [2:0]       termCode,
  input logic             timeoutFlag,
  input logic [CNT_W-1:0] burstCnt
);

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(statusOut)); // R1

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 4'b0001 && $past(statusOut) == 4'b0000) |->
      burstCnt == (($past(wide64Req) && !$past(wide64Ack)) ?
                   {$past(burstLen[CNT_W-2:0]), 1'b0} : $past(burstLen))); // R2

  AST_COUNT_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 4'b0010) |=> (burstCnt <= $past(burstCnt))); // R2

  AST_GRANT_LOST: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 4'b0001 && !busGrant) |=> (statusOut == 4'b0100 && termCode == 3'b110)); // R9

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 4'b0100) |=> (statusOut == 4'b0000 || statusOut == 4'b1000)); // R11

  AST_END_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 4'b0100 && !startReq) |=> $stable(burstCnt)); // R11

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 4'b0100 && startReq) |=> (statusOut == 4'b1000)); // R12

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 4'b0000 && !startReq) |=> ($stable(termCode) && $stable(timeoutFlag))); // R13

endmodule

bind masterBurstTracker bmtChecker #(.CNT_W(CNT_W)) u_bmtChecker (
  .clk(clk), .rstN(rstN), .startReq(startReq), .burstLen(burstLen),
  .wide64Req(wide64Req), .wide64Ack(wide64Ack), .busGrant(busGrant),
  .statusOut(statusOut), .termCode(termCode), .timeoutFlag(timeoutFlag),
  .burstCnt(burstCnt)
);

// File: tb/masterBurstTracker_test.sv
module masterBurstTracker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq, wide64Req, wide64Ack, mwiCmd, busGrant;
  logic        targetReady, targetStop, devSel, targetAbort, localAbort;
  logic [12:0] burstLen;
  logic [7:0]  latPreset, lineWords, startWord;
  logic [3:0]  statusOut;
  logic [2:0]  termCode;
  logic        timeoutFlag;
  logic [12:0] burstCnt;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  masterBurstTracker uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .burstLen(burstLen),
    .wide64Req(wide64Req), .wide64Ack(wide64Ack), .mwiCmd(mwiCmd),
    .busGrant(busGrant), .targetReady(targetReady), .targetStop(targetStop),
    .devSel(devSel), .targetAbort(targetAbort), .latPreset(latPreset),
    .lineWords(lineWords), .startWord(startWord), .localAbort(localAbort),
    .statusOut(statusOut), .termCode(termCode), .timeoutFlag(timeoutFlag),
    .burstCnt(burstCnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic quiet();
    startReq = 0; wide64Req = 0; wide64Ack = 0; mwiCmd = 0; busGrant = 1;
    targetReady = 0; targetStop = 0; devSel = 0; targetAbort = 0; localAbort = 0;
    burstLen = 0; latPreset = 8'd50; lineWords = 8'd4; startWord = 0;
  endtask

  // leaves the design in the address cycle
  task automatic begin_burst(input int len, input bit w64, input bit ack, input bit mwi,
                             input int preset);
    quiet();
    step();
    step();
    burstLen = 13'(len); wide64Req = w64; wide64Ack = ack; mwiCmd = mwi;
    latPreset = 8'(preset); startReq = 1;
    step();
    startReq = 0;
  endtask

  task automatic t_reset();
    chk("R1", "reset status", int'(statusOut), 0);
    chk("R13", "reset code", int'(termCode), 0);
    chk("R13", "reset flag", int'(timeoutFlag), 0);
  endtask

  task automatic t_normal();
    begin_burst(3, 0, 0, 0, 50);
    chk("R1", "address status", int'(statusOut), 1);
    chk("R2", "32-bit load", int'(burstCnt), 3);
    devSel = 1; targetReady = 1;
    step();
    chk("R1", "data status", int'(statusOut), 2);
    step(); step();
    chk("R2", "count after two phases", int'(burstCnt), 1);
    step();
    chk("R3", "normal end status", int'(statusOut), 4);
    chk("R3", "normal code", int'(termCode), 0);
    chk("R3", "normal flag", int'(timeoutFlag), 0);
    step();
    chk("R11", "end lasts one cycle", int'(statusOut), 0);
  endtask

  task automatic t_wide_and_local();
    begin_burst(4, 1, 0, 0, 50);
    chk("R2", "64-bit unacked load doubles", int'(burstCnt), 8);
    step();
    targetAbort = 1; targetStop = 1; localAbort = 1;
    step();
    chk("R7", "target abort ranks first", int'(termCode), 3);
    begin_burst(4, 1, 1, 0, 50);
    chk("R2", "64-bit acked load", int'(burstCnt), 4);
    chk("R13", "start clears code", int'(termCode), 0);
    step();
    localAbort = 1; targetStop = 1; devSel = 1;
    step();
    chk("R10", "local abort over stop", int'(termCode), 7);
    quiet();
    step(); step(); step();
    chk("R13", "code held while idle", int'(termCode), 7);
  endtask

  task automatic t_retry_disconnect();
    begin_burst(5, 0, 0, 0, 50);
    step();
    devSel = 1; targetStop = 1;
    step();
    chk("R8", "retry code", int'(termCode), 4);
    chk("R8", "retry count untouched", int'(burstCnt), 5);
    begin_burst(5, 0, 0, 0, 50);
    devSel = 1; targetReady = 1;
    step();
    step();
    targetStop = 1;
    step();
    chk("R8", "disconnect code", int'(termCode), 5);
    chk("R8", "disconnect count", int'(burstCnt), 3);
    targetStop = 0;
    step();
    chk("R11", "prefetch strobe not counted", int'(burstCnt), 3);
    chk("R11", "back to idle", int'(statusOut), 0);
  endtask

  task automatic t_master_abort();
    begin_burst(5, 0, 0, 0, 50);
    step();
    step(); step(); step();
    chk("R6", "still waiting after three", int'(statusOut), 2);
    step();
    chk("R6", "no response code", int'(termCode), 2);
    chk("R6", "no response ends", int'(statusOut), 4);
  endtask

  task automatic t_grant_lost();
    begin_burst(6, 0, 0, 0, 50);
    busGrant = 0;
    step();
    chk("R9", "grant lost status", int'(statusOut), 4);
    chk("R9", "grant lost code", int'(termCode), 6);
    chk("R9", "no data moved", int'(burstCnt), 6);
  endtask

  task automatic t_timeout();
    begin_burst(10, 0, 0, 0, 2);
    step();
    busGrant = 0; devSel = 1; targetReady = 1;
    step();
    chk("R4", "timer not yet expired", int'(statusOut), 2);
    step();
    chk("R4", "timeout code", int'(termCode), 1);
    chk("R4", "timeout flag", int'(timeoutFlag), 1);
    chk("R4", "timeout count", int'(burstCnt), 8);
  endtask

  task automatic t_expire_last();
    begin_burst(3, 0, 0, 0, 3);
    step();
    busGrant = 0; devSel = 1; targetReady = 1;
    step(); step(); step();
    chk("R3", "expiry on last is normal", int'(termCode), 0);
    chk("R3", "expiry on last sets flag", int'(timeoutFlag), 1);
    chk("R3", "ended", int'(statusOut), 4);
  endtask

  task automatic t_mwi();
    begin_burst(10, 0, 0, 1, 1);
    lineWords = 8'd4; startWord = 8'd0;
    step();
    busGrant = 0; devSel = 1; targetReady = 1; localAbort = 1;
    step(); step();
    chk("R5", "timer ignored mid-line", int'(statusOut), 2);
    chk("R5", "flag raised mid-line", int'(timeoutFlag), 1);
    step();
    chk("R5", "still mid-line", int'(statusOut), 2);
    step();
    chk("R5", "ends at line boundary", int'(statusOut), 4);
    chk("R5", "boundary code", int'(termCode), 1);
    chk("R5", "boundary count", int'(burstCnt), 6);
  endtask

  task automatic t_back_to_back();
    begin_burst(1, 0, 0, 0, 50);
    devSel = 1; targetReady = 1;
    step();
    step();
    chk("R3", "single phase ends", int'(statusOut), 4);
    startReq = 1; burstLen = 13'd2;
    step();
    startReq = 0;
    chk("R12", "back-to-back status", int'(statusOut), 8);
    chk("R12", "back-to-back load", int'(burstCnt), 2);
    step();
    chk("R12", "back-to-back data", int'(statusOut), 2);
  endtask

  initial begin
    quiet();
    step(); step();
    t_reset();
    rstN = 1;
    step();
    t_normal();
    t_wide_and_local();
    t_retry_disconnect();
    t_master_abort();
    t_grant_lost();
    t_timeout();
    t_expire_last();
    t_mwi();
    t_back_to_back();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule